// File: doc/BRIEF.md
# Output-Encoded Intersection Signal Controller

This block sequences the lights at a crossing of a main road and a side road. It steps through four phases in a fixed ring: main green, main yellow, side green, side yellow. Three plain control inputs drive it. One says a vehicle is waiting on the side road. One says the long interval has run out, and one says the short interval has run out. The interval timers sit outside the block and are restarted by a one-cycle `timer_start` pulse. The block raises that pulse in the same cycle in which it decides to change phase.

The block has no separate phase register. The four registered light bits (two for each road) are the state, because each phase drives a different light pattern. The next-phase logic reads the current light bits and the inputs, and writes the next light bits directly. `timer_start` is a combinational (Mealy) function of the current lights and the inputs. No input or output carries a data stream, so there is no valid/ready handshake and every pin is a level signal.

Top module: `traffic_phase_ctrl`

## Requirements
- R1: While `rst_n` is low, the main light is green, the side light is red and `timer_start` is 0.
- R2: Each light is 2 bits wide, with green = 2'b00, yellow = 2'b01 and red = 2'b10. The four phases drive these lights (main, side): main green = (00, 10), main yellow = (01, 10), side green = (10, 00), side yellow = (10, 01).
- R3: In main green, the block moves to main yellow at the next clock only when `car_waiting` and `long_expired` are both 1. Otherwise it stays in main green.
- R4: In main yellow, the block moves to side green at the next clock when `short_expired` is 1. Otherwise it stays in main yellow.
- R5: In side green, the block moves to side yellow at the next clock when `car_waiting` is 0 or `long_expired` is 1. It stays in side green while `car_waiting` = 1 and `long_expired` = 0.
- R6: In side yellow, the block moves to main green at the next clock when `short_expired` is 1. Otherwise it stays in side yellow.
- R7: `timer_start` is 1 in exactly those cycles in which the current lights and inputs select a phase change. It is 0 in every cycle in which the phase holds. It takes effect in the same cycle, with no register delay.
- R8: The two roads are never both showing something other than red.
- R9: The lights change only at a clock edge that follows a cycle with `timer_start` = 1. After such an edge they show the successor phase of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_waiting | input | 1 | A vehicle is waiting on the side road |
| long_expired | input | 1 | The long interval timer has run out |
| short_expired | input | 1 | The short interval timer has run out |
| timer_start | output | 1 | Restart the interval timers (phase change taken this cycle) |
| hwy_light | output | 2 | Main road light: 00 green, 01 yellow, 10 red |
| farm_light | output | 2 | Side road light: 00 green, 01 yellow, 10 red |

## Verification
The assertions assume the three inputs are stable and known around each rising clock edge. They also assume that reset is applied before the first edge, so the lights always start from one of the four valid patterns. The stimulus changes inputs only on the falling edge and drops reset shortly after time zero. It drives every combination of the three inputs in each phase, so every hold and every exit path is taken, including leaving side green both because the road is empty and because the long interval ran out. A reset applied in the middle of a run shows that the ring restarts at main green.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LIGHT_W = 2;
  localparam int PHASES  = 4;
  localparam int PH_W    = $clog2(PHASES);

  typedef enum logic [LIGHT_W-1:0] {
    LT_GREEN  = 2'b00,
    LT_YELLOW = 2'b01,
    LT_RED    = 2'b10,
    LT_BAD    = 2'b11
  } light_e;

  typedef struct packed {
    light_e hwy;
    light_e farm;
  } lights_t;

  // Phase index order is the ring order: 0 main green, 1 main yellow,
  // 2 side green, 3 side yellow.
  function automatic lights_t phase_pattern(input int unsigned idx);
    lights_t p;
    case (idx)
      0:       begin p.hwy = LT_GREEN;  p.farm = LT_RED;    end
      1:       begin p.hwy = LT_YELLOW; p.farm = LT_RED;    end
      2:       begin p.hwy = LT_RED;    p.farm = LT_GREEN;  end
      default: begin p.hwy = LT_RED;    p.farm = LT_YELLOW; end
    endcase
    return p;
  endfunction

  localparam lights_t RESET_LIGHTS = '{hwy: LT_GREEN, farm: LT_RED};
endpackage

// File: rtl/tlc_phase_decode.sv
module tlc_phase_decode
  import tlc_pkg::*;
(
  input  lights_t           cur,
  output logic [PHASES-1:0] phase_hot
);
  genvar gi;
  generate
    for (gi = 0; gi < PHASES; gi++) begin : g_match
      localparam lights_t PAT = phase_pattern(gi);
      assign phase_hot[gi] = (cur == PAT);
    end
  endgenerate
endmodule

// File: rtl/tlc_next_lights.sv
module tlc_next_lights
  import tlc_pkg::*;
(
  input  logic [PHASES-1:0] phase_hot,
  input  logic              car_waiting,
  input  logic              long_expired,
  input  logic              short_expired,
  input  lights_t           cur,
  output lights_t           nxt,
  output logic              change
);
  logic advance;

  always_comb begin
    advance = 1'b0;
    nxt     = RESET_LIGHTS;
    unique case (1'b1)
      phase_hot[0]: begin
        advance = car_waiting & long_expired;
        nxt     = advance ? phase_pattern(1) : cur;
      end
      phase_hot[1]: begin
        advance = short_expired;
        nxt     = advance ? phase_pattern(2) : cur;
      end
      phase_hot[2]: begin
        advance = ~car_waiting | long_expired;
        nxt     = advance ? phase_pattern(3) : cur;
      end
      phase_hot[3]: begin
        advance = short_expired;
        nxt     = advance ? phase_pattern(0) : cur;
      end
      default: begin
        advance = 1'b1;
        nxt     = RESET_LIGHTS;
      end
    endcase
    change = advance;
  end
endmodule

// File: rtl/tlc_light_reg.sv
module tlc_light_reg
  import tlc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  lights_t d,
  output lights_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_LIGHTS;
    else        q <= d;
  end
endmodule

// File: rtl/traffic_phase_ctrl.sv
module traffic_phase_ctrl
  import tlc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               car_waiting,
  input  logic               long_expired,
  input  logic               short_expired,
  output logic               timer_start,
  output logic [LIGHT_W-1:0] hwy_light,
  output logic [LIGHT_W-1:0] farm_light
);
  lights_t           cur_lights;
  lights_t           nxt_lights;
  logic [PHASES-1:0] phase_hot;
  logic              change;

  tlc_phase_decode u_dec (
    .cur       (cur_lights),
    .phase_hot (phase_hot)
  );

  tlc_next_lights u_next (
    .phase_hot     (phase_hot),
    .car_waiting   (car_waiting),
    .long_expired  (long_expired),
    .short_expired (short_expired),
    .cur           (cur_lights),
    .nxt           (nxt_lights),
    .change        (change)
  );

  tlc_light_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt_lights),
    .q     (cur_lights)
  );

  assign timer_start = rst_n & change;
  assign hwy_light   = cur_lights.hwy;
  assign farm_light  = cur_lights.farm;
endmodule

// File: rtl/tlc_checker.sv
module tlc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       car_waiting,
  input logic       long_expired,
  input logic       short_expired,
  input logic       timer_start,
  input logic [1:0] hwy_light,
  input logic [1:0] farm_light
);
  logic in_hg, in_hy, in_fg, in_fy;
  assign in_hg = (hwy_light == 2'b00) && (farm_light == 2'b10);
  assign in_hy = (hwy_light == 2'b01) && (farm_light == 2'b10);
  assign in_fg = (hwy_light == 2'b10) && (farm_light == 2'b00);
  assign in_fy = (hwy_light == 2'b10) && (farm_light == 2'b01);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (in_hg && !timer_start));

  assert_valid_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_hg, in_hy, in_fg, in_fy}));

  assert_hg_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hg && car_waiting && long_expired) |=> in_hy);
  assert_hg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hg && !(car_waiting && long_expired)) |=> in_hg);

  assert_hy_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_hy |=> (short_expired ? 1'b1 : 1'b1) && (in_hy || in_fg));
  assert_hy_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hy && short_expired) |=> in_fg);

  assert_fg_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fg && (!car_waiting || long_expired)) |=> in_fy);
  assert_fg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fg && car_waiting && !long_expired) |=> in_fg);

  assert_fy_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fy && short_expired) |=> in_hg);

  assert_pulse_on_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start |=> !($stable(hwy_light) && $stable(farm_light)));

  assert_conflict_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_light == 2'b10) || (farm_light == 2'b10));

  assert_hold_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_start |=> ($stable(hwy_light) && $stable(farm_light)));
endmodule

bind traffic_phase_ctrl tlc_checker u_tlc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .car_waiting   (car_waiting),
  .long_expired  (long_expired),
  .short_expired (short_expired),
  .timer_start   (timer_start),
  .hwy_light     (hwy_light),
  .farm_light    (farm_light)
);

// File: tb/tb_traffic_phase_ctrl.sv
`timescale 1ns/1ps
module tb_traffic_phase_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       car = 1'b0, lng = 1'b0, sht = 1'b0;
  logic       timer_start;
  logic [1:0] hwy_light, farm_light;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  traffic_phase_ctrl dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .car_waiting   (car),
    .long_expired  (lng),
    .short_expired (sht),
    .timer_start   (timer_start),
    .hwy_light     (hwy_light),
    .farm_light    (farm_light)
  );

  // Symbolic reference model
  typedef enum int {P_HG, P_HY, P_FG, P_FY} phase_e;
  phase_e model_ph = P_HG;

  typedef struct {
    logic       start;
    logic [1:0] hwy;
    logic [1:0] farm;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [3:0] pat(phase_e p);
    case (p)
      P_HG: return 4'b00_10;
      P_HY: return 4'b01_10;
      P_FG: return 4'b10_00;
      default: return 4'b10_01;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: set inputs on the falling edge and push the expectation
  task automatic drive(input logic c, input logic l, input logic s);
    exp_t   e;
    phase_e nx;
    logic   mv;
    @(negedge clk);
    car = c; lng = l; sht = s;
    case (model_ph)
      P_HG: begin mv = c & l;     nx = P_HY; e.tag = "R3"; end
      P_HY: begin mv = s;         nx = P_FG; e.tag = "R4"; end
      P_FG: begin mv = ~c | l;    nx = P_FY; e.tag = "R5"; end
      default: begin mv = s;      nx = P_HG; e.tag = "R6"; end
    endcase
    if (mv) model_ph = nx;
    e.start = mv;
    {e.hwy, e.farm} = pat(model_ph);
    sb_q.push_back(e);
  endtask

  // Monitor: sample the pulse mid-low-phase, lights after the edge
  logic obs_start;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      obs_start = timer_start;
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(obs_start === e.start, "R7", "timer_start", int'(obs_start), int'(e.start));
        check({hwy_light, farm_light} === {e.hwy, e.farm}, e.tag, "lights",
              int'({hwy_light, farm_light}), int'({e.hwy, e.farm}));
        check(hwy_light == 2'b10 || farm_light == 2'b10, "R8", "both roads open",
              int'({hwy_light, farm_light}), 0);
        check(obs_start || {hwy_light, farm_light} === {e.hwy, e.farm}, "R9",
              "lights moved without pulse", int'({hwy_light, farm_light}), int'({e.hwy, e.farm}));
      end
    end
  end

  task automatic check_reset_state(input string when);
    check({hwy_light, farm_light} === 4'b00_10, "R1", when, int'({hwy_light, farm_light}), 'h2);
    check(timer_start === 1'b0, "R1", "pulse in reset", int'(timer_start), 0);
  endtask

  task automatic drain();
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    car = 1'b1; lng = 1'b1; sht = 1'b1;
    repeat (3) @(posedge clk);
    #2 check_reset_state("reset lights");
    @(negedge clk);
    car = 1'b0; lng = 1'b0; sht = 1'b0;
    rst_n = 1'b1;
    #2 check({hwy_light, farm_light} === 4'b00_10, "R2", "main green pattern",
             int'({hwy_light, farm_light}), 'h2);

    // R3: main green holds without both car and long interval
    drive(1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    // R4: main yellow holds until short interval
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    // R5: side green holds while car and no long, leaves on empty road
    drive(1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    // R6: side yellow holds then returns
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    // Second ring: leave side green through long interval with car present
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    // Mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      drive(r[0], r[1], r[2]);
    end
    drain();

    // Mid-run reset from side green: ring restarts at main green (R1)
    while (model_ph != P_FG) drive(1'b1, ~model_ph[0], 1'b1);
    drive(1'b1, 1'b0, 1'b0);
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    #2 check_reset_state("mid-run reset");
    @(negedge clk);
    car = 1'b0; lng = 1'b0; sht = 1'b0;
    rst_n = 1'b1;
    model_ph = P_HG;
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule